// File: doc/BRIEF.md
# Associative Translation Buffer Lookup

This block translates a 32-bit virtual address into a physical address by searching every entry of a small, fully associative translation buffer in parallel. Each entry describes one page of 1 KB, 4 KB, 64 KB or 1 MB, carries an 8-bit address-space tag, a shared flag, a two-bit permission field and a dirty flag. A lookup request carries the address, the kind of access (read, write or instruction fetch) and the privilege of the requester. The current address-space tag, a single-virtual-space switch and a translation-enable switch are plain control inputs, sampled when the request is accepted.

Some address windows are never translated. The block maps them directly and faults them when the requester is unprivileged. When translation is disabled, every other address is folded into the low 512 MB. Otherwise the block reports one of three results: a translation, a miss, or one of several fault codes. A fault code tells the consumer why the access failed: a missing page, a protection violation, a first write to a clean page, or an ambiguous match.

Requests use a valid/ready handshake and so do results. One request is accepted in a cycle where `req_valid` and `req_ready` are both high. The result appears on the next cycle with `rsp_valid` high. It stays unchanged until a cycle in which `rsp_ready` is high. `req_ready` is low exactly while a result is held back, so a consumer that keeps `rsp_ready` low stalls the producer. Entries are loaded through a separate write port that is not flow-controlled.

Top module: `tlbx_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and every entry is invalid, so a translated lookup misses.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` high) produces its result with `rsp_valid` high right after that edge. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and all `rsp_*` outputs hold still. A result is consumed on an edge where `rsp_ready` is high, and a new request may be accepted on that same edge.
- R3: For a privileged request, addresses 0x80000000–0xBFFFFFFF give `rsp_paddr` = address AND 0x1FFFFFFF. Addresses 0xE0000000 and above give `rsp_paddr` = address. Neither case faults, and both apply whatever `xlate_en` is.
- R4: For an unprivileged request, those same windows fault with code 0x0E0 for read or fetch and 0x100 for write. The exception is 0xE0000000–0xE3FFFFFF, which passes unchanged without a fault.
- R5: When `xlate_en` is 0, every other address gives `rsp_paddr` = address AND 0x1FFFFFFF with no fault, in either privilege mode and for any access.
- R6: An entry takes part in a match only when its valid bit is set. When the tag check is active, a non-shared entry must also hold a tag equal to `cur_asid`. The tag check is active unless `single_vm` is 1 and the request is privileged.
- R7: The size code selects the page: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. To find the page base, shift the entry's virtual page number left by 10 and clear the in-page bits. The address matches when it lies between that base and base + size − 1.
- R8: With exactly one match and no fault, `rsp_paddr` = (physical page number shifted left by 10, with the in-page bits cleared) OR (the in-page bits of the address). `rsp_code` is 0. With exactly one match, `rsp_hit` is 1 and `rsp_idx` is the index of the matching entry, fault or not. In every other case both are 0. Whenever `rsp_code` is nonzero, `rsp_fault` is 1 and `rsp_paddr` is 0.
- R9: Two or more matching entries give code 0x140.
- R10: No matching entry gives code 0x040 for read or fetch and 0x060 for write.
- R11: For an unprivileged request that hits an entry with permission bit 1 clear, the code is 0x0A0 for read or fetch and 0x0C0 for write.
- R12: A write that passes R11 faults with 0x0C0 when permission bit 0 is clear. If permission bit 0 is set but the dirty bit is clear, it faults with 0x080. Reads and fetches ignore permission bit 0 and the dirty bit.
- R13: A cycle with `ent_we` high replaces every field of entry `ent_idx` on that edge. Requests accepted on later edges see the new contents.
- R14: `req_acc` encodes 0 = read, 1 = write, 2 = fetch. The value 3 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Requester is privileged |
| cur_asid | input | 8 | Current address-space tag |
| single_vm | input | 1 | Single virtual space switch |
| xlate_en | input | 1 | Translation enable |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Entry to write |
| ent_vpn | input | 22 | Virtual page number (address bits 31:10) |
| ent_asid | input | 8 | Entry address-space tag |
| ent_ppn | input | 19 | Physical page number (address bits 28:10) |
| ent_size | input | 2 | Page size code |
| ent_valid | input | 1 | Entry valid |
| ent_shared | input | 1 | Entry ignores the tag check |
| ent_prot | input | 2 | Bit 1: user access allowed; bit 0: write allowed |
| ent_dirty | input | 1 | Page already written |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Fault code, 0 on success |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_idx | output | IDX_W | Index of the matching entry |

## Verification
Every result is due exactly one clock edge after the edge that accepts its request, because the only register between request and result is the output stage. The bench drives a request at a falling edge, lets one rising edge accept it, and reads the result at the next falling edge, half a period clear of any edge. Hold behaviour is checked over several stalled cycles, followed by a release edge that consumes the old result and accepts a new request at once; the new result is read one falling edge later. Entry writes are driven at a falling edge and take effect at the following rising edge, and lookups that depend on them are issued only after that edge.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 10;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PA_W       = 29;
  localparam int PPN_W      = PA_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int CODE_W     = 12;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [CODE_W-1:0] FC_NONE     = 12'h000;
  localparam logic [CODE_W-1:0] FC_MISS_RD  = 12'h040;
  localparam logic [CODE_W-1:0] FC_MISS_WR  = 12'h060;
  localparam logic [CODE_W-1:0] FC_FIRST_WR = 12'h080;
  localparam logic [CODE_W-1:0] FC_PROT_RD  = 12'h0A0;
  localparam logic [CODE_W-1:0] FC_PROT_WR  = 12'h0C0;
  localparam logic [CODE_W-1:0] FC_AREA_RD  = 12'h0E0;
  localparam logic [CODE_W-1:0] FC_AREA_WR  = 12'h100;
  localparam logic [CODE_W-1:0] FC_MULTI    = 12'h140;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        size;
    logic [1:0]        prot;
    logic              dirty;
  } tlb_entry_t;

  // In-page offset mask for a size code
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    logic [VA_W-1:0] m;
    case (sz)
      2'd0:    m = (VA_W'(1) << PAGE_SHIFT) - 1;
      2'd1:    m = (VA_W'(1) << (PAGE_SHIFT + 2)) - 1;
      2'd2:    m = (VA_W'(1) << (PAGE_SHIFT + 6)) - 1;
      default: m = (VA_W'(1) << (PAGE_SHIFT + 10)) - 1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tlbx_entry_store.sv
module tlbx_entry_store
  import tlbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [IDX_W-1:0] widx,
  input  tlb_entry_t wdata,
  output tlb_entry_t ents [NUM_ENTRIES]
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        ents[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  tlb_entry_t         ents [NUM_ENTRIES],
  input  logic [VA_W-1:0]    vaddr,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic               asid_chk,
  output logic [NUM_ENTRIES-1:0] hit_vec
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [VA_W-1:0] keep;
    logic            tag_ok;
    logic            addr_ok;
    assign keep    = ~page_mask(ents[g].size);
    assign tag_ok  = ents[g].shared || !asid_chk || (ents[g].asid == cur_asid);
    assign addr_ok = (vaddr & keep) == ({ents[g].vpn, {PAGE_SHIFT{1'b0}}} & keep);
    assign hit_vec[g] = ents[g].valid && tag_ok && addr_ok;
  end

endmodule

// File: rtl/tlbx_resolve.sv
module tlbx_resolve
  import tlbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  tlb_entry_t             ents [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  input  logic [VA_W-1:0]        vaddr,
  input  logic [1:0]             acc,
  input  logic                   priv,
  input  logic                   xlate_en,
  output logic [CODE_W-1:0]      code,
  output logic [VA_W-1:0]        paddr,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);

  logic             is_wr;
  logic             in_direct;
  logic             in_top;
  logic             in_queue;
  logic             any_hit;
  logic             multi_hit;
  logic [IDX_W-1:0] sel;
  tlb_entry_t       e;
  logic [VA_W-1:0]  off;

  assign is_wr     = (acc_e'(acc) == ACC_WRITE);
  assign in_direct = (vaddr[31:30] == 2'b10);
  assign in_top    = (vaddr[31:29] == 3'b111);
  assign in_queue  = (vaddr[31:26] == 6'b111000);

  // Reduce the match vector to any / more-than-one / encoded index
  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    sel       = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i]) begin
        multi_hit = multi_hit | any_hit;
        any_hit   = 1'b1;
        sel       = sel | IDX_W'(i);
      end
    end
  end

  assign e   = ents[sel];
  assign off = page_mask(e.size);

  always_comb begin
    code  = FC_NONE;
    paddr = '0;
    hit   = 1'b0;
    idx   = '0;
    if (in_direct || in_top) begin
      if (!priv && !in_queue) begin
        code = is_wr ? FC_AREA_WR : FC_AREA_RD;
      end else if (in_direct) begin
        paddr = {3'b000, vaddr[28:0]};
      end else begin
        paddr = vaddr;
      end
    end else if (!xlate_en) begin
      paddr = {3'b000, vaddr[28:0]};
    end else if (multi_hit) begin
      code = FC_MULTI;
    end else if (!any_hit) begin
      code = is_wr ? FC_MISS_WR : FC_MISS_RD;
    end else begin
      hit = 1'b1;
      idx = sel;
      if (!priv && !e.prot[1]) begin
        code = is_wr ? FC_PROT_WR : FC_PROT_RD;
      end else if (is_wr && !e.prot[0]) begin
        code = FC_PROT_WR;
      end else if (is_wr && !e.dirty) begin
        code = FC_FIRST_WR;
      end else begin
        paddr = ({{(VA_W-PA_W){1'b0}}, e.ppn, {PAGE_SHIFT{1'b0}}} & ~off) | (vaddr & off);
      end
    end
  end

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter  int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_priv,
  input  logic [7:0]        cur_asid,
  input  logic              single_vm,
  input  logic              xlate_en,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [21:0]       ent_vpn,
  input  logic [7:0]        ent_asid,
  input  logic [18:0]       ent_ppn,
  input  logic [1:0]        ent_size,
  input  logic              ent_valid,
  input  logic              ent_shared,
  input  logic [1:0]        ent_prot,
  input  logic              ent_dirty,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [11:0]       rsp_code,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx
);

  tlb_entry_t             ents [NUM_ENTRIES];
  tlb_entry_t             wdata;
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic                   asid_chk;
  logic                   accept;
  logic [CODE_W-1:0]      nxt_code;
  logic [VA_W-1:0]        nxt_paddr;
  logic                   nxt_hit;
  logic [IDX_W-1:0]       nxt_idx;

  assign wdata = '{valid: ent_valid, shared: ent_shared, asid: ent_asid,
                   vpn: ent_vpn, ppn: ent_ppn, size: ent_size,
                   prot: ent_prot, dirty: ent_dirty};

  tlbx_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ent_we),
    .widx  (ent_idx),
    .wdata (wdata),
    .ents  (ents)
  );

  assign asid_chk = !(single_vm && req_priv);

  tlbx_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .ents     (ents),
    .vaddr    (req_vaddr),
    .cur_asid (cur_asid),
    .asid_chk (asid_chk),
    .hit_vec  (hit_vec)
  );

  tlbx_resolve #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_resolve (
    .ents     (ents),
    .hit_vec  (hit_vec),
    .vaddr    (req_vaddr),
    .acc      (req_acc),
    .priv     (req_priv),
    .xlate_en (xlate_en),
    .code     (nxt_code),
    .paddr    (nxt_paddr),
    .hit      (nxt_hit),
    .idx      (nxt_idx)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= (nxt_code != FC_NONE);
      rsp_code  <= nxt_code;
      rsp_paddr <= nxt_paddr;
      rsp_hit   <= nxt_hit;
      rsp_idx   <= nxt_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/tlbx_lookup_chk.sv
module tlbx_lookup_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_vaddr,
  input logic             req_priv,
  input logic             xlate_en,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [11:0]      rsp_code,
  input logic [31:0]      rsp_paddr,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_idx
);

  logic acc_q;
  assign acc_q = req_valid && req_ready;

  // R2: an accepted request yields a result on the next cycle
  a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> rsp_valid);

  // R2: a stalled result is held unchanged
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_paddr)
                                   && $stable(rsp_hit) && $stable(rsp_idx)));

  // R3: privileged access to the direct window strips the top three bits
  a_r3_direct_window: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && req_priv && (req_vaddr[31:30] == 2'b10))
      |=> (!rsp_fault && (rsp_paddr == {3'b000, $past(req_vaddr[28:0])})));

  // R5: translation disabled folds low addresses without fault
  a_r5_xlate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !xlate_en && !req_vaddr[31])
      |=> (!rsp_fault && (rsp_paddr == {3'b000, $past(req_vaddr[28:0])})));

  // R8: a fault never carries an address
  a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

  // R9: an ambiguous match is not reported as a hit
  a_r9_multi_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code == 12'h140)) |-> (!rsp_hit && (rsp_idx == '0)));

endmodule

bind tlbx_lookup tlbx_lookup_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .req_priv  (req_priv),
  .xlate_en  (xlate_en),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_fault (rsp_fault),
  .rsp_code  (rsp_code),
  .rsp_paddr (rsp_paddr),
  .rsp_hit   (rsp_hit),
  .rsp_idx   (rsp_idx)
);

// File: tb/tlbx_lookup_tb.sv
module tlbx_lookup_tb;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_vaddr = '0;
  logic [1:0]    req_acc = '0;
  logic          req_priv = 1'b0;
  logic [7:0]    cur_asid = '0;
  logic          single_vm = 1'b0;
  logic          xlate_en = 1'b0;
  logic          ent_we = 1'b0;
  logic [IW-1:0] ent_idx = '0;
  logic [21:0]   ent_vpn = '0;
  logic [7:0]    ent_asid = '0;
  logic [18:0]   ent_ppn = '0;
  logic [1:0]    ent_size = '0;
  logic          ent_valid = 1'b0;
  logic          ent_shared = 1'b0;
  logic [1:0]    ent_prot = '0;
  logic          ent_dirty = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_fault;
  logic [11:0]   rsp_code;
  logic [31:0]   rsp_paddr;
  logic          rsp_hit;
  logic [IW-1:0] rsp_idx;

  always #10 clk = ~clk;

  tlbx_lookup #(.NUM_ENTRIES(N)) u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Shadow of entry contents kept by the bench
  bit [21:0] s_vpn [N];
  bit [7:0]  s_asid[N];
  bit [18:0] s_ppn [N];
  bit [1:0]  s_size[N];
  bit        s_val [N];
  bit        s_shr [N];
  bit [1:0]  s_prot[N];
  bit        s_dirty[N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic put_entry(input int i, input bit [31:0] va, input bit [7:0] asid,
                           input bit [18:0] ppn, input bit [1:0] sz, input bit v,
                           input bit shr, input bit [1:0] prot, input bit dirty);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = IW'(i); ent_vpn = va[31:10]; ent_asid = asid;
    ent_ppn = ppn; ent_size = sz; ent_valid = v; ent_shared = shr;
    ent_prot = prot; ent_dirty = dirty;
    s_vpn[i] = va[31:10]; s_asid[i] = asid; s_ppn[i] = ppn; s_size[i] = sz;
    s_val[i] = v; s_shr[i] = shr; s_prot[i] = prot; s_dirty[i] = dirty;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  function automatic longint page_bytes(input bit [1:0] sz);
    case (sz)
      2'd0: return 64'd1024;
      2'd1: return 64'd4096;
      2'd2: return 64'd65536;
      default: return 64'd1048576;
    endcase
  endfunction

  // Expected result, worked out from the requirements
  task automatic model(input bit [31:0] va, input bit [1:0] acc, input bit priv,
                       input bit [7:0] asid, input bit svm, input bit xen,
                       output bit [11:0] code, output bit [31:0] pa,
                       output bit hit, output int idx, output string tag);
    bit     wr;
    int     nm;
    int     mi;
    bit     chk_tag;
    longint sz, st, en;
    wr = (acc == 2'd1);
    code = 12'h0; pa = 32'h0; hit = 1'b0; idx = 0;
    if ((va >= 32'h8000_0000 && va <= 32'hBFFF_FFFF) || va >= 32'hE000_0000) begin
      if (!priv && !(va <= 32'hE3FF_FFFF && va >= 32'hE000_0000)) begin
        code = wr ? 12'h100 : 12'h0E0; tag = "R4";
      end else begin
        pa = (va < 32'hC000_0000) ? (va & 32'h1FFF_FFFF) : va;
        tag = priv ? "R3" : "R4";
      end
      return;
    end
    if (!xen) begin
      pa = va & 32'h1FFF_FFFF; tag = "R5";
      return;
    end
    chk_tag = !(svm && priv);
    nm = 0; mi = 0;
    for (int i = 0; i < N; i++) begin
      if (s_val[i] && (s_shr[i] || !chk_tag || s_asid[i] == asid)) begin
        sz = page_bytes(s_size[i]);
        st = longint'({s_vpn[i], 10'b0}) & ~(sz - 1);
        en = st + sz - 1;
        if (longint'(va) >= st && longint'(va) <= en) begin
          nm++; mi = i;
        end
      end
    end
    if (nm > 1) begin code = 12'h140; tag = "R9"; return; end
    if (nm == 0) begin code = wr ? 12'h060 : 12'h040; tag = "R10"; return; end
    hit = 1'b1; idx = mi;
    if (!priv && !s_prot[mi][1]) begin
      code = wr ? 12'h0C0 : 12'h0A0; tag = "R11";
    end else if (wr && !s_prot[mi][0]) begin
      code = 12'h0C0; tag = "R12";
    end else if (wr && !s_dirty[mi]) begin
      code = 12'h080; tag = "R12";
    end else begin
      sz = page_bytes(s_size[mi]);
      pa = 32'((longint'({s_ppn[mi], 10'b0}) & ~(sz - 1)) | (longint'(va) & (sz - 1)));
      tag = "R8";
    end
  endtask

  // Drive at a falling edge, accept at the rising edge, read at the next falling edge
  task automatic lookup(input bit [31:0] va, input bit [1:0] acc, input bit priv,
                        input bit [7:0] asid, input bit svm, input bit xen,
                        input string force_tag);
    bit [11:0] ec; bit [31:0] ep; bit eh; int ei; string tg;
    model(va, acc, priv, asid, svm, xen, ec, ep, eh, ei, tg);
    if (force_tag != "") tg = force_tag;
    req_vaddr = va; req_acc = acc; req_priv = priv; cur_asid = asid;
    single_vm = svm; xlate_en = xen; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", longint'(rsp_valid), 1);
    chk(rsp_code == ec, tg, $sformatf("code va=%08h acc=%0d p=%0d", va, acc, priv),
        longint'(rsp_code), longint'(ec));
    chk(rsp_fault == (ec != 0), tg, "fault", longint'(rsp_fault), longint'(ec != 0));
    chk(rsp_paddr == ep, tg, $sformatf("paddr va=%08h", va), longint'(rsp_paddr), longint'(ep));
    chk(rsp_hit == eh, tg, "hit", longint'(rsp_hit), longint'(eh));
    chk(rsp_idx == IW'(ei), tg, "idx", longint'(rsp_idx), longint'(ei));
  endtask

  bit [31:0] tva[32];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      s_val[i] = 0; s_vpn[i] = 0; s_asid[i] = 0; s_ppn[i] = 0;
      s_size[i] = 0; s_shr[i] = 0; s_prot[i] = 0; s_dirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", longint'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
    lookup(32'h0001_0000, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R1");
    lookup(32'h0040_0000, 2'd2, 1'b1, 8'd9, 1'b1, 1'b1, "R1");

    // Entry set-up (R13 load path)
    put_entry(0, 32'h0001_0000, 8'd5, 19'h12345, 2'd0, 1, 0, 2'b11, 1);
    put_entry(1, 32'h0040_0000, 8'd9, 19'h0ABCD, 2'd1, 1, 1, 2'b10, 0);
    put_entry(2, 32'h0100_0000, 8'd5, 19'h54321, 2'd2, 1, 0, 2'b01, 1);
    put_entry(3, 32'h100A_BC00, 8'd5, 19'h7FFFF, 2'd3, 1, 0, 2'b11, 0);
    put_entry(4, 32'h0001_0000, 8'd7, 19'h00042, 2'd1, 1, 0, 2'b11, 1);
    put_entry(5, 32'h2000_0000, 8'd5, 19'h11111, 2'd0, 0, 0, 2'b11, 1);

    // Address list: each mapped page's ends and neighbours, then the windows
    begin
      bit [31:0] bases[5];
      int        szs[5];
      bases = '{32'h0001_0000, 32'h0040_0000, 32'h0100_0000, 32'h1000_0000, 32'h0001_0000};
      szs   = '{1024, 4096, 65536, 1048576, 4096};
      for (int k = 0; k < 5; k++) begin
        tva[4*k+0] = bases[k];
        tva[4*k+1] = bases[k] + 32'(szs[k]) - 1;
        tva[4*k+2] = bases[k] + 32'(szs[k]);
        tva[4*k+3] = bases[k] - 1;
      end
      tva[20] = 32'h8000_1234; tva[21] = 32'hBFFF_FFFF; tva[22] = 32'hA000_0010;
      tva[23] = 32'hC000_0000; tva[24] = 32'hDFFF_FFFF; tva[25] = 32'hE000_0000;
      tva[26] = 32'hE3FF_FFFC; tva[27] = 32'hE400_0000; tva[28] = 32'hFFFF_FFFF;
      tva[29] = 32'h7FFF_FFFF; tva[30] = 32'h2000_0000; tva[31] = 32'h0000_0000;
    end

    // Sweep: every address x access x privilege x single-space x enable x tag
    for (int a = 0; a < 32; a++)
      for (int ac = 0; ac < 4; ac++)
        for (int p = 0; p < 2; p++)
          for (int sv = 0; sv < 2; sv++)
            for (int xe = 0; xe < 2; xe++)
              for (int t = 0; t < 3; t++) begin
                bit [7:0] as;
                as = (t == 0) ? 8'd5 : ((t == 1) ? 8'd7 : 8'd9);
                lookup(tva[a], 2'(ac), p[0], as, sv[0], xe[0], "");
              end

    // R6: shared entry ignores the tag; single-space privileged bypass
    lookup(32'h0040_0010, 2'd0, 1'b0, 8'd3, 1'b0, 1'b1, "R6");
    lookup(32'h0100_0010, 2'd0, 1'b1, 8'd3, 1'b1, 1'b1, "R6");
    lookup(32'h0100_0010, 2'd0, 1'b1, 8'd3, 1'b0, 1'b1, "R6");
    // R7: 1 MB page, stray low page-number bits ignored
    lookup(32'h100F_FFFF, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R7");
    lookup(32'h1010_0000, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R7");
    // R14: access code 3 behaves as a read
    lookup(32'h0001_0000, 2'd3, 1'b1, 8'd5, 1'b0, 1'b1, "R14");
    lookup(32'h0001_0000, 2'd3, 1'b0, 8'd0, 1'b0, 1'b1, "R14");

    // R13: rewriting an entry changes later lookups
    lookup(32'h2000_0004, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R13");
    put_entry(5, 32'h2000_0000, 8'd5, 19'h11111, 2'd0, 1, 0, 2'b11, 1);
    lookup(32'h2000_0004, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R13");
    put_entry(0, 32'h0001_0000, 8'd5, 19'h12345, 2'd0, 0, 0, 2'b11, 1);
    lookup(32'h0001_0000, 2'd0, 1'b1, 8'd5, 1'b1, 1'b1, "R13");

    // R2: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_vaddr = 32'h8000_0040; req_acc = 2'd0; req_priv = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2", "stall first result valid", longint'(rsp_valid), 1);
    chk(rsp_paddr == 32'h0000_0040, "R2", "stall first paddr", longint'(rsp_paddr), 32'h40);
    req_vaddr = 32'h9000_0000;
    #1;
    chk(req_ready == 1'b0, "R2", "req_ready while stalled", longint'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk(rsp_paddr == 32'h0000_0040, "R2", "held paddr", longint'(rsp_paddr), 32'h40);
    chk(rsp_valid == 1'b1, "R2", "held valid", longint'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", "second result valid", longint'(rsp_valid), 1);
    chk(rsp_paddr == 32'h1000_0000, "R2", "second paddr", longint'(rsp_paddr), 32'h1000_0000);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "drained", longint'(rsp_valid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule